// File: doc/BRIEF.md
# Up-Counting Timer with Control Register

This block is a 16-bit up-counting timer run by a small control register. Software uses a register port with one cycle of read latency to start and stop the counter and to pick its behaviour. The choices are an update-event gate, a source filter for the update flag, a single-shot mode that stops the counter, and buffered or direct loading of the reload limit. The block also has a switch that copies the update flag into the top bit of the counter read-back, so one read returns the count and the flag together.

The counter counts from zero up to the active reload value and then wraps. Each wrap is an update event, which sets a sticky flag and can move a buffered reload value into the active register. Software can also force an update event through a separate address. A divider produces a registered tick every 1, 2 or 4 clocks, which later sampling and dead-time logic can use as its enable.

Address map on `addr_i`: 0 control, 1 status (bit 0 is the update flag), 2 event trigger (bit 0 forces an update), 3 counter, 4 reload. Any other address reads as zero.

Top module: `tmr_ctl_top`

## Requirements
- R1: After reset, the control register, the status register and the counter read as zero, the reload register reads 0x0000FFFF, and `upd_flag_o` is 0.
- R2: Control register bit positions: bit 0 enable, bit 1 update gate (UG), bit 2 overflow-only flag source (OS), bit 3 single-shot, bit 7 reload buffering, bits 9:8 divide code, bit 11 flag mirror. All other bits read as zero and ignore writes. Read data appears on `rdata_o` one clock after `addr_i` is presented.
- R3: While enabled, the counter increments once per clock. In the clock where it equals the active reload value, it returns to zero instead, which is an update event. That event sets the update flag.
- R4: With reload buffering off, a write to the reload address takes effect in the active limit at once.
- R5: With reload buffering on, a reload write goes only to a buffer. The buffer moves into the active limit at the next update event. Reads of the reload address return the buffer.
- R6: With UG set, a wrap is not an update event. The counter still returns to zero, but the flag is not set and no buffer transfer happens.
- R7: With single-shot set, the update event clears the enable bit in hardware, so the counter stops at zero.
- R8: Writing 1 to bit 0 of the event address with UG clear forces an update event. The forced event zeroes the counter and transfers the buffer. It sets the flag only when OS is clear.
- R9: With OS set, a counter wrap still sets the flag.
- R10: Writing 0 to status bit 0 clears the flag. Writing 1 leaves it unchanged.
- R11: A counter read returns the count in bits 15:0. Bit 31 holds the update flag when the mirror bit is set and reads as zero otherwise.
- R12: `tick_o` pulses once every 1, 2 or 4 clocks for divide codes 00, 01 and 10. The reserved code 11 behaves as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_i | input | 1 | Synchronous active-high reset |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | 3 | Register address, used for both reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data for the address presented in the previous clock |
| upd_flag_o | output | 1 | Sticky update flag |
| tick_o | output | 1 | Divided sampling enable pulse |

## Verification
The assertions assume the write strobe and the address are stable over each clock edge and carry no unknown values. They also assume that no forced update is requested in the same cycle as a control write that changes the enable. The stimulus drives every input on the falling edge, one register access per cycle, and never combines an event write with a control write. Reads are issued on consecutive cycles, so each read-back of the counter is one clock after the previous one. Every expected count is therefore the read index modulo the reload value plus one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_EVT  = 3'd2,
    A_CNT  = 3'd3,
    A_RLD  = 3'd4
  } addr_e;

  // writable bits of the control word
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_0B8F;

  typedef struct packed {
    logic       remap;
    logic [1:0] ckd;
    logic       arpe;
    logic       opm;
    logic       urs;
    logic       udis;
    logic       cen;
  } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hw_stop_i,
  output ctrl_t             ctrl_o
);
  logic wr_ctrl;
  assign wr_ctrl = we_i && (addr_i == A_CTRL);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_o <= '0;
    end else if (wr_ctrl) begin
      ctrl_o.cen   <= wdata_i[0];
      ctrl_o.udis  <= wdata_i[1];
      ctrl_o.urs   <= wdata_i[2];
      ctrl_o.opm   <= wdata_i[3];
      ctrl_o.arpe  <= wdata_i[7];
      ctrl_o.ckd   <= wdata_i[9:8];
      ctrl_o.remap <= wdata_i[11];
    end else if (hw_stop_i) begin
      ctrl_o.cen <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  ctrl_t             ctrl_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_buf_o,
  output logic [CNT_W-1:0]  rld_act_o,
  output logic              flag_o,
  output logic              uev_o
);
  localparam logic [CNT_W-1:0] RLD_RST = {CNT_W{1'b1}};

  logic wr_cnt, wr_rld, wr_stat, force_req, wrap, flag_set;

  assign wr_cnt    = we_i && (addr_i == A_CNT);
  assign wr_rld    = we_i && (addr_i == A_RLD);
  assign wr_stat   = we_i && (addr_i == A_STAT);
  assign force_req = we_i && (addr_i == A_EVT) && wdata_i[0];
  assign wrap      = ctrl_i.cen && (cnt_o == rld_act_o);
  assign uev_o     = (wrap || force_req) && !ctrl_i.udis;
  assign flag_set  = uev_o && (wrap || !ctrl_i.urs);

  always_ff @(posedge clk_i) begin
    if (rst_i)                         cnt_o <= '0;
    else if (wr_cnt)                   cnt_o <= wdata_i[CNT_W-1:0];
    else if (force_req && !ctrl_i.udis) cnt_o <= '0;
    else if (wrap)                     cnt_o <= '0;
    else if (ctrl_i.cen)               cnt_o <= cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rld_buf_o <= RLD_RST;
      rld_act_o <= RLD_RST;
    end else begin
      if (wr_rld) rld_buf_o <= wdata_i[CNT_W-1:0];
      if (wr_rld && !ctrl_i.arpe) rld_act_o <= wdata_i[CNT_W-1:0];
      else if (uev_o)             rld_act_o <= rld_buf_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                       flag_o <= 1'b0;
    else if (flag_set)               flag_o <= 1'b1;
    else if (wr_stat && !wdata_i[0]) flag_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_sampdiv.sv
module tmr_sampdiv #(
  parameter int DIV_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] ckd_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    case (ckd_i)
      2'b00:   mask = '0;
      2'b01:   mask = DIV_W'(1);
      default: mask = DIV_W'(3);
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      div_q  <= div_q + 1'b1;
      tick_o <= ((div_q & mask) == mask);
    end
  end
endmodule

// File: rtl/tmr_ctl_top.sv
module tmr_ctl_top
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              upd_flag_o,
  output logic              tick_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt, rld_buf, rld_act;
  logic             uev;
  logic [DATA_W-1:0] rd_nxt;

  tmr_ctrl_reg u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .hw_stop_i(uev && ctrl_q.opm), .ctrl_o(ctrl_q)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ctrl_i(ctrl_q), .cnt_o(cnt), .rld_buf_o(rld_buf),
    .rld_act_o(rld_act), .flag_o(upd_flag_o), .uev_o(uev)
  );

  tmr_sampdiv #(.DIV_W(2)) u_div (
    .clk_i(clk_i), .rst_i(rst_i), .ckd_i(ctrl_q.ckd), .tick_o(tick_o)
  );

  always_comb begin
    rd_nxt = '0;
    case (addr_i)
      A_CTRL: begin
        rd_nxt[0]   = ctrl_q.cen;
        rd_nxt[1]   = ctrl_q.udis;
        rd_nxt[2]   = ctrl_q.urs;
        rd_nxt[3]   = ctrl_q.opm;
        rd_nxt[7]   = ctrl_q.arpe;
        rd_nxt[9:8] = ctrl_q.ckd;
        rd_nxt[11]  = ctrl_q.remap;
      end
      A_STAT: rd_nxt[0] = upd_flag_o;
      A_CNT: begin
        rd_nxt[CNT_W-1:0] = cnt;
        rd_nxt[DATA_W-1]  = ctrl_q.remap && upd_flag_o;
      end
      A_RLD:   rd_nxt[CNT_W-1:0] = rld_buf;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else       rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/tmr_ctl_chk.sv
module tmr_ctl_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              flag,
  input logic              tick,
  input logic              cen,
  input logic              opm,
  input logic              udis,
  input logic              remap,
  input logic [1:0]        ckd,
  input logic              uev,
  input logic [CNT_W-1:0]  rld_act
);
  a_r2_rsv_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_i == A_CTRL) |=> ((rdata_o & ~CTRL_MASK) == '0));

  a_r7_opm_stop: assert property (@(posedge clk_i) disable iff (rst_i)
    (uev && opm && !(we_i && addr_i == A_CTRL)) |=> !cen);

  a_r3_flag_needs_uev: assert property (@(posedge clk_i) disable iff (rst_i)
    (!flag && !uev) |=> !flag);

  a_r6_gate_holds_limit: assert property (@(posedge clk_i) disable iff (rst_i)
    (udis && !(we_i && addr_i == A_RLD)) |=> $stable(rld_act));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag && !uev && we_i && addr_i == A_STAT && !wdata_i[0]) |=> !flag);

  a_r11_no_mirror: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_i == A_CNT && !remap) |=> !rdata_o[DATA_W-1]);

  a_r12_fast_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    (ckd == 2'b00) |=> tick);
endmodule

bind tmr_ctl_top tmr_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .flag(upd_flag_o), .tick(tick_o),
  .cen(ctrl_q.cen), .opm(ctrl_q.opm), .udis(ctrl_q.udis),
  .remap(ctrl_q.remap), .ckd(ctrl_q.ckd), .uev(uev), .rld_act(rld_act)
);

// File: tb/tmr_ctl_top_tb.sv
module tmr_ctl_top_tb;
  localparam int AC = 0, AS = 1, AE = 2, AN = 3, AR = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        flag, tick;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  tmr_ctl_top u_dut (
    .clk_i(clk), .rst_i(rst), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .upd_flag_o(flag), .tick_o(tick)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 3'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 3'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int last, cnt_t, per;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 flag", {31'b0, flag}, 0);
    rd(AC, v); chk("R1 ctrl", v, 0);
    rd(AS, v); chk("R1 status", v, 0);
    rd(AN, v); chk("R1 count", v, 0);
    rd(AR, v); chk("R1 reload", v, 32'h0000_FFFF);

    // R3/R4 sweep of direct reload limits
    for (int a = 0; a < 8; a++) begin
      wr(AC, 0); wr(AR, a); wr(AN, 0); wr(AS, 0); wr(AC, 1);
      for (int i = 0; i < 12; i++) begin
        rd(AN, v); chk("R3/R4 count", v, i % (a + 1));
      end
      chk("R3 flag", {31'b0, flag}, 1);
    end

    // R5 buffered reload
    wr(AC, 0); wr(AR, 7); wr(AC, 32'h80); wr(AR, 3);
    rd(AR, v); chk("R5 buffer read", v, 3);
    wr(AN, 0); wr(AC, 32'h81);
    for (int i = 0; i < 16; i++) begin
      rd(AN, v); chk("R5 count", v, (i < 8) ? i : (i - 8) % 4);
    end

    // R6 update gate
    wr(AC, 32'h80); wr(AR, 5); wr(AC, 32'h82); wr(AN, 0); wr(AS, 0); wr(AC, 32'h83);
    for (int i = 0; i < 10; i++) begin
      rd(AN, v); chk("R6 count", v, i % 4);
    end
    chk("R6 flag", {31'b0, flag}, 0);
    wr(AC, 32'h80);

    // R8 forced update
    wr(AE, 1);
    chk("R8 flag", {31'b0, flag}, 1);
    rd(AN, v); chk("R8 zeroed", v, 0);
    wr(AC, 32'h81);
    for (int i = 0; i < 8; i++) begin
      rd(AN, v); chk("R8 count", v, i % 6);
    end
    wr(AC, 32'h84); wr(AR, 2); wr(AS, 0); wr(AE, 1);
    chk("R8 no flag with OS", {31'b0, flag}, 0);
    wr(AC, 32'h85);
    for (int i = 0; i < 6; i++) begin
      rd(AN, v); chk("R8 count", v, i % 3);
    end
    chk("R9 flag", {31'b0, flag}, 1);
    wr(AC, 0);

    // R10 flag clear
    wr(AS, 1);
    chk("R10 write one", {31'b0, flag}, 1);
    rd(AS, v); chk("R10 status", v, 1);
    wr(AS, 0);
    chk("R10 write zero", {31'b0, flag}, 0);
    rd(AS, v); chk("R10 status", v, 0);

    // R7 single-shot
    wr(AR, 4); wr(AN, 0); wr(AC, 32'h9);
    for (int i = 0; i < 8; i++) begin
      rd(AN, v); chk("R7 count", v, (i < 5) ? i : 0);
    end
    rd(AC, v); chk("R7 ctrl", v, 32'h8);
    chk("R7 flag", {31'b0, flag}, 1);

    // R11 mirror
    wr(AC, 32'h800); rd(AN, v); chk("R11 mirror on", v, 32'h8000_0000);
    wr(AC, 0);       rd(AN, v); chk("R11 mirror off", v, 0);
    wr(AC, 32'h800); wr(AS, 0); rd(AN, v); chk("R11 flag clear", v, 0);

    // R2 layout
    wr(AC, 32'hFFFF_FFFF);
    rd(AC, v); chk("R2 ctrl mask", v, 32'h0000_0B8F);
    wr(AC, 0);
    rd(AC, v); chk("R2 ctrl zero", v, 0);

    // R12 divider
    for (int c = 0; c < 4; c++) begin
      per = (c == 0) ? 1 : (c == 1) ? 2 : 4;
      wr(AC, c << 8);
      repeat (3) @(negedge clk);
      cnt_t = 0; last = -1;
      for (int i = 0; i < 32; i++) begin
        if (tick) begin
          if (last >= 0) chk("R12 spacing", i - last, per);
          last = i; cnt_t++;
        end
        @(negedge clk);
      end
      chk("R12 count", cnt_t, 32 / per);
    end

    finish_run();
  end
endmodule